// File: doc/BRIEF.md
# PHY Management Serial Master

This block is the host-side master of the two-wire PHY management bus. It drives a management clock and a single data line that a pad cell turns into one bidirectional pin. One instance serves both Ethernet ports of a chip. Software reaches it through a small register window with simple write and read strobes.

A host first selects the target by writing a PHY number and a register number. It then starts a transfer in one of three ways:
- Writing the write-data register sends a write frame at once.
- Setting the one-shot read bit in the command register runs a single read.
- Setting the scan bit runs read frames back to back until software clears it.

Two status flags report progress. A busy flag covers any frame in flight. A separate not-valid flag stays set from the moment a read is requested until the read-data register holds a fresh word from the PHY.

Each frame is 64 bits long, in this order:
- 32 ones of preamble;
- the start pair 01;
- the opcode, 10 for a read or 01 for a write;
- the PHY and register numbers, five bits each, MSB first;
- two turnaround bits;
- sixteen data bits, MSB first.

Outgoing bits change on the falling edge of the management clock. Incoming bits are sampled on the rising edge. During a read the line is released from the first turnaround bit to the last data bit.

Top module: `mdio_master`

## Requirements
- R1: After reset the management clock is low, the data line is released (mdio_oe = 0), the status register reads 0, the read-data register reads 0, and the divider register reads its reset value of 9.
- R2: The management clock stays high for exactly N+1 system clocks and low for exactly N+1 system clocks, where N is the value in the divider register (host address 5, bits [7:0]).
- R3: A write frame on the line is 32 driven ones, then 0 1, then opcode 0 1, then the PHY number (target register bits [12:8]) and the register number (target register bits [4:0]), each MSB first, then turnaround 1 0, then the 16 data bits MSB first, with mdio_oe high for every bit.
- R4: A host write to the write-data register (address 2) while idle starts a write frame to the selected target. Status bit 0 (busy) reads 1 from the next register read until the frame ends, then reads 0.
- R5: A read frame carries opcode 1 0 and the selected PHY and register numbers. mdio_oe is low for both turnaround bits and all 16 data bits. The 16 bits the PHY returns, sampled on rising management clock edges, appear in the read-data register (address 3).
- R6: Writing 1 to command bit 0 (address 1) while idle runs exactly one read frame. Status bit 1 (not-valid) reads 1 until that read's data is in the read-data register, then reads 0.
- R7: While command bit 1 (scan) is set, read frames of the selected target repeat without host action, and the read-data register follows the newest result. Once the bit is cleared and the frame in flight has ended, no further frame starts.
- R8: mdio_o and mdio_oe change only in the system clock cycle in which the management clock falls.
- R9: Command bit 0 always reads back as 0. Command bit 1 reads back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe, one cycle per write |
| host_addr | input | 3 | Register address (0 target, 1 command, 2 write data, 3 read data, 4 status, 5 divider) |
| host_wdata | input | 16 | Register write data |
| host_rdata | output | 16 | Register read data, registered one cycle after host_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value to drive onto the bidirectional pin |
| mdio_oe | output | 1 | Pin output enable, high while the master drives |
| mdio_i | input | 1 | Value seen on the bidirectional pin |

## Verification
Writes use two data patterns, 16'hA55A and 16'h0001, sent to the highest and lowest PHY numbers with opposite register numbers. The patterns expose bit-order and field-swap faults in the frame assembly. Single reads with two different targets return target-dependent words from a PHY model, so a stale or misaligned capture cannot match. A scan run of at least three frames uses a serial-dependent word, which separates a register that follows each new result from one that holds the first. The clock divider is measured at its reset value and at 1, which catches off-by-one errors in the half-period count.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ID_W      = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * ID_W + 2 + DATA_W;
  localparam int TA_POS    = PRE_LEN + 4 + 2 * ID_W;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_DRIVE = 2'b10;

  typedef enum logic [2:0] {
    RA_TARGET = 3'd0,
    RA_CMD    = 3'd1,
    RA_WDATA  = 3'd2,
    RA_RDATA  = 3'd3,
    RA_STATUS = 3'd4,
    RA_DIV    = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_lim,
  output logic             mdc,
  output logic             rise_tk,
  output logic             fall_tk
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             hit;

  // a tick marks the cycle whose closing edge toggles the clock
  assign hit     = (cnt_q >= half_lim);
  assign rise_tk = hit && !mdc_q;
  assign fall_tk = hit && mdc_q;
  assign mdc     = mdc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame import mdio_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ID_W-1:0]   phy_id,
  input  logic [ID_W-1:0]   reg_id,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              done_rd,
  output logic [DATA_W-1:0] rd_word
);
  logic [FRAME_LEN-1:0] sr_q;
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W:0]       idx_nxt;
  logic                 active_q, pend_q, is_rd_q;
  logic                 do_q, oe_q, done_q;
  logic [DATA_W-1:0]    cap_q;
  logic [FRAME_LEN-1:0] frame_img;

  always_comb begin
    frame_img = {{PRE_LEN{1'b1}}, SOF_BITS,
                 start_rd ? OP_READ : OP_WRITE,
                 phy_id, reg_id,
                 start_rd ? 2'b11 : TA_DRIVE,
                 start_rd ? {DATA_W{1'b0}} : wr_word};
  end

  assign idx_nxt = {1'b0, idx_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      is_rd_q  <= 1'b0;
      do_q     <= 1'b1;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      cap_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        pend_q  <= 1'b1;
        is_rd_q <= start_rd;
        sr_q    <= frame_img;
      end
      if (fall_tk) begin
        if (pend_q) begin
          pend_q   <= 1'b0;
          active_q <= 1'b1;
          idx_q    <= '0;
          do_q     <= sr_q[FRAME_LEN-1];
          sr_q     <= {sr_q[FRAME_LEN-2:0], 1'b0};
          oe_q     <= 1'b1;
        end else if (active_q) begin
          if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
            active_q <= 1'b0;
            oe_q     <= 1'b0;
            do_q     <= 1'b1;
            done_q   <= 1'b1;
          end else begin
            idx_q <= idx_nxt[IDX_W-1:0];
            do_q  <= sr_q[FRAME_LEN-1];
            sr_q  <= {sr_q[FRAME_LEN-2:0], 1'b0};
            oe_q  <= !(is_rd_q && (idx_nxt >= (IDX_W+1)'(TA_POS)));
          end
        end
      end
      if (rise_tk && active_q && is_rd_q && (idx_q >= IDX_W'(DATA_POS)))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
    end
  end

  assign mdio_o  = do_q;
  assign mdio_oe = oe_q;
  assign done    = done_q;
  assign done_rd = done_q && is_rd_q;
  assign rd_word = cap_q;

  // R8
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe_q) |-> $past(fall_tk));
  // R8
  data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(do_q) |-> $past(fall_tk));
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (!active_q && !pend_q));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs import mdio_pkg::*; #(
  parameter int               HOST_DW = 16,
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [2:0]         host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               frame_done,
  input  logic               frame_done_rd,
  input  logic [DATA_W-1:0]  rd_word,
  output logic               start,
  output logic               start_rd,
  output logic [ID_W-1:0]    phy_id,
  output logic [ID_W-1:0]    reg_id,
  output logic [DATA_W-1:0]  wr_word,
  output logic [DIV_W-1:0]   half_lim
);
  logic [ID_W-1:0]    phy_q, reg_q;
  logic [DATA_W-1:0]  wdat_q, rdat_q;
  logic [DIV_W-1:0]   div_q;
  logic               busy_q, nv_q, scan_q;
  logic [HOST_DW-1:0] rdata_q;
  logic               hit_tgt, hit_cmd, hit_wd, hit_div;
  logic               go_wr, go_rd, cmd_rd_ok, scan_rise;
  logic               unused_bits;

  assign hit_tgt = host_we && (host_addr == RA_TARGET);
  assign hit_cmd = host_we && (host_addr == RA_CMD);
  assign hit_wd  = host_we && (host_addr == RA_WDATA);
  assign hit_div = host_we && (host_addr == RA_DIV);

  // a write request outranks a read request in the same cycle
  assign go_wr     = !busy_q && hit_wd;
  assign cmd_rd_ok = !busy_q && !hit_wd && hit_cmd && host_wdata[0];
  assign go_rd     = !busy_q && !hit_wd && ((hit_cmd && host_wdata[0]) || scan_q);
  assign scan_rise = hit_cmd && host_wdata[1] && !scan_q;

  assign start    = go_wr || go_rd;
  assign start_rd = !go_wr;
  assign phy_id   = phy_q;
  assign reg_id   = reg_q;
  assign wr_word  = host_wdata[DATA_W-1:0];
  assign half_lim = div_q;

  assign unused_bits = ^{host_wdata[HOST_DW-1:13], host_wdata[7:5], wdat_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_q  <= '0;
      reg_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      div_q  <= DIV_RST;
      busy_q <= 1'b0;
      nv_q   <= 1'b0;
      scan_q <= 1'b0;
    end else begin
      if (hit_tgt) begin
        phy_q <= host_wdata[8+ID_W-1:8];
        reg_q <= host_wdata[ID_W-1:0];
      end
      if (hit_wd)  wdat_q <= host_wdata[DATA_W-1:0];
      if (hit_div) div_q  <= host_wdata[DIV_W-1:0];
      if (hit_cmd) scan_q <= host_wdata[1];
      if (start)           busy_q <= 1'b1;
      else if (frame_done) busy_q <= 1'b0;
      if (frame_done_rd) begin
        rdat_q <= rd_word;
        nv_q   <= 1'b0;
      end
      if (cmd_rd_ok || scan_rise) nv_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      unique case (host_addr)
        RA_TARGET: rdata_q <= HOST_DW'({phy_q, 3'b000, reg_q});
        RA_CMD:    rdata_q <= HOST_DW'({scan_q, 1'b0});
        RA_WDATA:  rdata_q <= HOST_DW'(wdat_q);
        RA_RDATA:  rdata_q <= HOST_DW'(rdat_q);
        RA_STATUS: rdata_q <= HOST_DW'({nv_q, busy_q});
        RA_DIV:    rdata_q <= HOST_DW'(div_q);
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign host_rdata = rdata_q;

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(frame_done));
  // R6
  nv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(nv_q) |-> $past(frame_done_rd));
endmodule

// File: rtl/mdio_master.sv
module mdio_master import mdio_pkg::*; #(
  parameter int               HOST_DW = 16,
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [2:0]         host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic              rise_tk, fall_tk;
  logic              start, start_rd, done, done_rd;
  logic [ID_W-1:0]   phy_id, reg_id;
  logic [DATA_W-1:0] wr_word, rd_word;
  logic [DIV_W-1:0]  half_lim;

  mdio_regs #(.HOST_DW(HOST_DW), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_done(done), .frame_done_rd(done_rd), .rd_word(rd_word),
    .start(start), .start_rd(start_rd),
    .phy_id(phy_id), .reg_id(reg_id), .wr_word(wr_word),
    .half_lim(half_lim)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .half_lim(half_lim),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mdio_frame u_frame (
    .clk(clk), .rst(rst),
    .rise_tk(rise_tk), .fall_tk(fall_tk),
    .start(start), .start_rd(start_rd),
    .phy_id(phy_id), .reg_id(reg_id), .wr_word(wr_word),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .done_rd(done_rd), .rd_word(rd_word)
  );
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] rg;
    logic [15:0] dat;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [15:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  item_t exp_q[$];
  bit    scan_on = 1'b0;
  logic [4:0] scan_phy, scan_rg;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      chk(1'b0, "WDOG", "run did not end", cyc, WATCHDOG);
      finish_run();
    end
  end

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r, input int s);
    return {p, r, 6'h2A} ^ (16'(s) * 16'h1357);
  endfunction

  // PHY model and monitor: decodes frames at rising mdc, compares with scoreboard
  int         ones = 0;
  bit         in_fr = 1'b0;
  int         k = 0;
  logic [12:0] hdr;
  logic [1:0] ta;
  logic [15:0] dat;
  logic [15:0] rd_val;
  bit         fr_rd = 1'b0;
  bit         drv_bad, rel_bad;
  int         frames = 0;
  int         rd_serial = 0;

  always @(posedge mdc) begin
    if (!rst) begin
      if (!in_fr) begin
        if (mdio_oe && mdio_o) ones++;
        else if (mdio_oe && !mdio_o && ones >= 32) begin
          chk(ones == 32, "R3", "preamble length", ones, 32);
          in_fr = 1'b1; k = 0; ones = 0; drv_bad = 1'b0; rel_bad = 1'b0;
        end else ones = 0;
      end else begin
        k++;
        if (k <= 13) begin
          if (!mdio_oe) drv_bad = 1'b1;
          hdr = {hdr[11:0], mdio_o};
          if (k == 13) begin
            fr_rd  = (hdr[11:10] == 2'b10);
            rd_val = phy_val(hdr[9:5], hdr[4:0], rd_serial);
          end
        end else if (fr_rd) begin
          if (mdio_oe) rel_bad = 1'b1;
        end else begin
          if (!mdio_oe) drv_bad = 1'b1;
          if (k <= 15) ta = {ta[0], mdio_o};
          else dat = {dat[14:0], mdio_o};
        end
        if (k == 31) begin
          item_t e;
          bit have;
          frames++;
          in_fr = 1'b0;
          have = 1'b1;
          if (exp_q.size() > 0) e = exp_q.pop_front();
          else if (scan_on) e = '{rd: 1'b1, phy: scan_phy, rg: scan_rg, dat: 16'h0};
          else begin
            have = 1'b0;
            chk(1'b0, "R7", "frame with nothing requested", frames, 0);
          end
          if (have) begin
            chk(hdr[12] == 1'b1, "R3", "start bits", hdr[12], 1);
            chk(hdr[11:10] == (e.rd ? 2'b10 : 2'b01), e.rd ? "R5" : "R3", "opcode", hdr[11:10], e.rd ? 2 : 1);
            chk(hdr[9:5] == e.phy, "R3", "phy field", hdr[9:5], e.phy);
            chk(hdr[4:0] == e.rg, "R3", "register field", hdr[4:0], e.rg);
            if (e.rd) begin
              chk(!rel_bad, "R5", "line released in turnaround and data", rel_bad, 0);
              chk(!drv_bad, "R5", "header driven", drv_bad, 0);
              rd_serial++;
            end else begin
              chk(!drv_bad, "R3", "all bits driven", drv_bad, 0);
              chk(ta == 2'b10, "R3", "turnaround", ta, 2);
              chk(dat == e.dat, "R3", "write data", dat, e.dat);
            end
          end
        end
      end
    end
  end

  always @(negedge mdc) begin
    if (in_fr && fr_rd && k >= 14 && k <= 30)
      mdio_in <= (k == 14) ? 1'b0 : rd_val[30-k];
    else
      mdio_in <= 1'b1;
  end

  // R8 monitor: line changes only in the cycle mdc falls
  logic p_o, p_oe, p_mdc;
  bit   mon_on = 1'b0;
  always @(negedge clk) begin
    if (mon_on && (mdio_o !== p_o || mdio_oe !== p_oe))
      chk(p_mdc === 1'b1 && mdc === 1'b0, "R8", "line change away from falling mdc", {p_mdc, mdc}, 2);
    p_o = mdio_o; p_oe = mdio_oe; p_mdc = mdc;
    if (!rst) mon_on = 1'b1;
  end

  task automatic host_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); host_addr = a;
    @(posedge clk); #1; d = host_rdata;
  endtask

  task automatic wait_idle;
    logic [15:0] s;
    s = 16'h1;
    while (s[0]) host_rd(3'd4, s);
  endtask

  task automatic measure(input string req, input int exp_half);
    int hi, lo;
    hi = 0; lo = 0;
    @(posedge mdc);
    @(negedge clk);
    while (mdc) begin hi++; @(negedge clk); end
    while (!mdc) begin lo++; @(negedge clk); end
    chk(hi == exp_half, req, "mdc high time", hi, exp_half);
    chk(lo == exp_half, req, "mdc low time", lo, exp_half);
  endtask

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [15:0] s;
    exp_q.push_back('{rd: 1'b0, phy: p, rg: r, dat: d});
    host_wr(3'd0, {3'b0, p, 3'b0, r});
    host_wr(3'd2, d);
    host_rd(3'd4, s);
    chk(s[0] == 1'b1, "R4", "busy after write launch", s, 1);
    wait_idle();
    host_rd(3'd4, s);
    chk(s == 16'h0, "R4", "status after write", s, 0);
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r);
    logic [15:0] s, v, expv;
    int f0;
    host_wr(3'd0, {3'b0, p, 3'b0, r});
    expv = phy_val(p, r, rd_serial);
    exp_q.push_back('{rd: 1'b1, phy: p, rg: r, dat: expv});
    f0 = frames;
    host_wr(3'd1, 16'h0001);
    host_rd(3'd4, s);
    chk(s[1:0] == 2'b11, "R6", "not-valid and busy while pending", s, 3);
    host_rd(3'd1, s);
    chk(s == 16'h0, "R9", "read bit reads back 0", s, 0);
    wait_idle();
    host_rd(3'd4, s);
    chk(s == 16'h0, "R6", "not-valid cleared", s, 0);
    host_rd(3'd3, v);
    chk(v == expv, "R5", "read data", v, expv);
    repeat (300) @(posedge clk);
    chk(frames == f0 + 1, "R6", "exactly one frame", frames, f0 + 1);
  endtask

  initial begin
    logic [15:0] v;
    int f0;
    repeat (4) @(posedge clk);
    #1;
    chk(mdc == 1'b0, "R1", "mdc in reset", mdc, 0);
    chk(mdio_oe == 1'b0, "R1", "oe in reset", mdio_oe, 0);
    @(negedge clk); rst = 1'b0;
    host_rd(3'd4, v); chk(v == 16'h0, "R1", "status after reset", v, 0);
    host_rd(3'd5, v); chk(v == 16'd9, "R1", "divider after reset", v, 9);
    host_rd(3'd3, v); chk(v == 16'h0, "R1", "read data after reset", v, 0);

    measure("R2", 10);
    host_wr(3'd5, 16'd1);
    measure("R2", 2);

    do_write(5'h1F, 5'h00, 16'hA55A);
    do_write(5'h00, 5'h1F, 16'h0001);

    do_read(5'h03, 5'h11);
    do_read(5'h1C, 5'h02);

    // R7 scan run
    scan_phy = 5'h0A; scan_rg = 5'h05;
    host_wr(3'd0, {3'b0, scan_phy, 3'b0, scan_rg});
    scan_on = 1'b1;
    f0 = frames;
    host_wr(3'd1, 16'h0002);
    host_rd(3'd4, v);
    chk(v[1] == 1'b1, "R6", "not-valid set at scan start", v, 2);
    host_rd(3'd1, v);
    chk(v == 16'h0002, "R9", "scan bit reads back", v, 2);
    while (frames < f0 + 3) @(posedge clk);
    host_wr(3'd1, 16'h0000);
    wait_idle();
    scan_on = 1'b0;
    host_rd(3'd3, v);
    chk(v == phy_val(scan_phy, scan_rg, rd_serial - 1), "R7", "read data follows newest scan",
        v, phy_val(scan_phy, scan_rg, rd_serial - 1));
    host_rd(3'd4, v);
    chk(v == 16'h0, "R7", "status after scan stop", v, 0);
    f0 = frames;
    repeat (400) @(posedge clk);
    chk(frames == f0, "R7", "no frame after scan cleared", frames, f0);
    chk(exp_q.size() == 0, "R4", "all requested frames seen", exp_q.size(), 0);
    finish_run();
  end
endmodule